// File: doc/BRIEF.md
# Inline Frame CRC Checker and End-Delimiter Marker

This block sits in the forwarding path of a cut-through switch port. It takes a stream of 32-bit words, one per clock, each with a 3-bit tag. The tag says whether the word is ordinary frame content, a start delimiter, one of four end delimiters, or a primitive. Every word leaves the block exactly one clock after it arrives. The block never holds back a frame to wait for its check result.

While words pass through, the block runs a CRC over each frame, starting with the start-delimiter word. The word just before the end delimiter is taken as the transmitted CRC. When the two values disagree, the block rewrites the tag of the outgoing end delimiter into its invalid form. The data word itself is left as it is, so the damaged frame still reaches its destination and the receiver can drop it at once.

Two saturating counters record errors. The first counts every frame that fails the check. The second counts only failing frames that arrived with a still-valid end delimiter. Comparing the two counters across the ports of a path shows where the corruption first appeared.

Top module: `fc_crc_inline_marker`

## Requirements
- R1: Every input word, whatever its tag, appears on out_word/out_tag with out_valid high on the clock edge after it is accepted (in_valid high), and out_valid is low one edge after in_valid is low.
- R2: The check uses CRC-32 with polynomial 0x04C11DB7 and a start value of 0xFFFFFFFF. Each word is fed bit 31 first, and the final value is bit-inverted. The CRC covers the start-delimiter word through the last payload word. The word right before the end delimiter must equal that inverted value.
- R3: The tag codes are: 0 frame word, 1 start delimiter, 2 normal end, 3 terminate end, 4 normal end invalid, 5 terminate end invalid, 6 primitive, 7 reserved. On a failed check, an end code of 2 leaves as 4 and an end code of 3 leaves as 5. The data word is not changed.
- R4: An end delimiter that arrives already marked invalid (code 4 or 5) leaves with its tag unchanged, even when the check also fails.
- R5: crc_err_cnt increments once for every frame whose check fails, whatever its end code (2 to 5).
- R6: crc_geof_cnt increments only for a failing frame whose end code was 2 or 3.
- R7: Primitive words (code 6) and reserved words (code 7) pass through unchanged. They are excluded from the CRC even inside a frame, and they do not end a frame.
- R8: A start delimiter that arrives inside a frame abandons that frame without touching either counter and starts a new CRC.
- R9: Both counters stop at all ones (0xFFFF at the default width). A high cnt_clr zeroes both counters on the next edge, and this takes priority over an increment in the same cycle.
- R10: A frame whose check passes leaves with its end tag unchanged, and neither counter moves.
- R11: After reset, out_valid is low, both counters are zero and no frame is open.
- R12: An end delimiter or frame word that arrives while no frame is open passes through unchanged and moves no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of both error counters |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Input data word |
| in_tag | input | 3 | Input word tag (codes in R3) |
| out_valid | output | 1 | Output word present |
| out_word | output | 32 | Forwarded data word |
| out_tag | output | 3 | Forwarded tag, possibly rewritten to an invalid end code |
| crc_err_cnt | output | 16 | Count of frames failing the check |
| crc_geof_cnt | output | 16 | Count of failing frames that arrived with a valid end code |

## Verification
The hardest case to reach from the ports is counter saturation, and a clear landing in the same cycle as a failing frame. Reaching the top of a 16-bit counter would take more failing frames than a short run allows. The bench therefore builds the block with 4-bit counters, sends a run of corrupted frames past the limit, and then raises cnt_clr exactly in the cycle that carries a failing end delimiter. Frames interrupted by a fresh start delimiter, primitives placed inside frames, and frames with no payload words are mixed in as well. These cover the frame-tracking corners, and a reference model compares every output on every clock.

// File: rtl/fcm_pkg.sv
// Package: shared tag codes and helpers for the inline CRC marker.
// Assumes a 3-bit tag travels alongside each 32-bit word.
package fcm_pkg;

    localparam int TAG_W = 3;

    typedef enum logic [TAG_W-1:0] {
        TAG_DATA   = 3'd0,
        TAG_SOF    = 3'd1,
        TAG_EOF_N  = 3'd2,
        TAG_EOF_T  = 3'd3,
        TAG_EOF_NI = 3'd4,
        TAG_EOF_TI = 3'd5,
        TAG_PRIM   = 3'd6,
        TAG_RSVD   = 3'd7
    } tag_e;

    // True for any of the four end delimiter codes.
    function automatic logic is_eof(input logic [TAG_W-1:0] t);
        return (t == TAG_EOF_N) || (t == TAG_EOF_T) ||
               (t == TAG_EOF_NI) || (t == TAG_EOF_TI);
    endfunction

    // True for an end delimiter that is not yet marked invalid.
    function automatic logic is_eof_good(input logic [TAG_W-1:0] t);
        return (t == TAG_EOF_N) || (t == TAG_EOF_T);
    endfunction

    // Maps a valid end delimiter onto its invalid counterpart.
    function automatic logic [TAG_W-1:0] to_invalid(input logic [TAG_W-1:0] t);
        logic [TAG_W-1:0] r;
        case (t)
            TAG_EOF_N: r = TAG_EOF_NI;
            TAG_EOF_T: r = TAG_EOF_TI;
            default:   r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcm_crc_step.sv
// Module: fcm_crc_step
// Purely combinational CRC update over one full data word, fed MSB
// first, non-reflected. Assumes the CRC width equals the word width.
module fcm_crc_step #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data,
    output logic [W-1:0] crc_out
);

    // Bit-serial update folded into one cycle.
    function automatic logic [W-1:0] advance(input logic [W-1:0] c0,
                                             input logic [W-1:0] d);
        logic [W-1:0] c;
        logic         fb;
        c = c0;
        for (int b = W - 1; b >= 0; b--) begin
            fb = c[W-1] ^ d[b];
            c  = {c[W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    // Drive the next CRC state from the current one and the word.
    always_comb crc_out = advance(crc_in, data);

endmodule

// File: rtl/fcm_frame_tracker.sv
// Module: fcm_frame_tracker
// Follows frame boundaries on the tagged stream and keeps two running
// CRC values: one over every frame word so far, and one that lags by a
// word. At an end delimiter the lagging value, inverted, must equal the
// last frame word (the carried CRC). Primitive and reserved words are
// ignored. Assumes at most one word per cycle.
module fcm_frame_tracker
    import fcm_pkg::*;
#(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7,
    parameter logic [W-1:0] INIT = 32'hFFFFFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_word,
    input  logic [TAG_W-1:0] in_tag,
    output logic             check_now,
    output logic             crc_bad
);

    logic         in_frame;
    logic [W-1:0] crc_cur;
    logic [W-1:0] crc_lag;
    logic [W-1:0] last_word;
    logic [W-1:0] crc_src;
    logic [W-1:0] crc_nxt;
    logic         is_start;
    logic         is_body;

    // Classify the current input word.
    always_comb begin
        is_start = in_valid && (in_tag == TAG_SOF);
        is_body  = in_valid && in_frame && (in_tag == TAG_DATA);
        crc_src  = is_start ? INIT : crc_cur;
    end

    fcm_crc_step #(.W(W), .POLY(POLY)) u_step (
        .crc_in (crc_src),
        .data   (in_word),
        .crc_out(crc_nxt)
    );

    // Frame state and the two running CRC registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            crc_cur   <= INIT;
            crc_lag   <= INIT;
            last_word <= '0;
        end else if (is_start) begin
            in_frame  <= 1'b1;
            crc_lag   <= INIT;
            crc_cur   <= crc_nxt;
            last_word <= in_word;
        end else if (is_body) begin
            crc_lag   <= crc_cur;
            crc_cur   <= crc_nxt;
            last_word <= in_word;
        end else if (check_now) begin
            in_frame  <= 1'b0;
        end
    end

    // Verdict for an end delimiter that closes an open frame.
    always_comb begin
        check_now = in_valid && in_frame && is_eof(in_tag);
        crc_bad   = (last_word != ~crc_lag);
    end

endmodule

// File: rtl/fcm_sat_counter.sv
// Module: fcm_sat_counter
// Up counter that stops at all ones, with a synchronous clear that wins
// over an increment in the same cycle.
module fcm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    // Count, saturate, clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

endmodule

// File: rtl/fc_crc_inline_marker.sv
// Module: fc_crc_inline_marker (top)
// Forwards each tagged word with one register of delay. A frame that
// fails its CRC check has its valid end tag swapped for the invalid
// form on the way out. Two error counters record the failures. Assumes
// the carried CRC word sits directly before the end delimiter.
module fc_crc_inline_marker
    import fcm_pkg::*;
#(
    parameter int           DATA_W = 32,
    parameter int           CNT_W  = 16,
    parameter logic [DATA_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [DATA_W-1:0] INIT = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    input  logic [2:0]        in_tag,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic [2:0]        out_tag,
    output logic [CNT_W-1:0]  crc_err_cnt,
    output logic [CNT_W-1:0]  crc_geof_cnt
);

    logic             check_now;
    logic             crc_bad;
    logic             fail_any;
    logic             fail_good;
    logic [TAG_W-1:0] tag_fwd;

    fcm_frame_tracker #(.W(DATA_W), .POLY(POLY), .INIT(INIT)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_word  (in_word),
        .in_tag   (in_tag),
        .check_now(check_now),
        .crc_bad  (crc_bad)
    );

    // Decide failure events and the outgoing tag.
    always_comb begin
        fail_any  = check_now && crc_bad;
        fail_good = fail_any && is_eof_good(in_tag);
        tag_fwd   = fail_good ? to_invalid(in_tag) : in_tag;
    end

    // One-cycle forwarding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_tag   <= TAG_DATA;
        end else begin
            out_valid <= in_valid;
            out_word  <= in_word;
            out_tag   <= tag_fwd;
        end
    end

    fcm_sat_counter #(.W(CNT_W)) u_err_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (fail_any),
        .count(crc_err_cnt)
    );

    fcm_sat_counter #(.W(CNT_W)) u_geof_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (fail_good),
        .count(crc_geof_cnt)
    );

endmodule

// File: rtl/fcm_checker.sv
// Module: fcm_checker
// Property checks on the top-level ports, attached through bind.
module fcm_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_word,
    input logic [2:0]        in_tag,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_word,
    input logic [2:0]        out_tag,
    input logic [CNT_W-1:0]  crc_err_cnt,
    input logic [CNT_W-1:0]  crc_geof_cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_word_intact: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_word == $past(in_word));
    a_r4_invalid_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_tag == 3'd4 || in_tag == 3'd5)) |=> out_tag == $past(in_tag));
    a_r7_non_eof_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tag != 3'd2 && in_tag != 3'd3) |=> out_tag == $past(in_tag));
    a_r3_rewrite_target: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_tag == 3'd2) |=> (out_tag == 3'd2 || out_tag == 3'd4));
    a_r6_geof_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        crc_geof_cnt <= crc_err_cnt);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (crc_err_cnt == '0 && crc_geof_cnt == '0));
    a_r9_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && crc_err_cnt == TOP) |=> crc_err_cnt == TOP);
    a_r5_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> crc_err_cnt >= $past(crc_err_cnt));

endmodule

bind fc_crc_inline_marker fcm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_clr     (cnt_clr),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_tag      (in_tag),
    .out_valid   (out_valid),
    .out_word    (out_word),
    .out_tag     (out_tag),
    .crc_err_cnt (crc_err_cnt),
    .crc_geof_cnt(crc_geof_cnt)
);

// File: tb/sim_fc_crc_inline_marker.sv
`timescale 1ns/1ps
// Bench: behavioural reference model (word queue per frame, whole-frame
// CRC at the end delimiter) compared with the outputs every clock.
module sim_fc_crc_inline_marker;

    localparam int          CNT_W = 4;
    localparam logic [31:0] POLY  = 32'h04C11DB7;
    localparam int          TOPC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clr = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [2:0]  in_tag = '0;
    logic out_valid;
    logic [31:0] out_word;
    logic [2:0]  out_tag;
    logic [CNT_W-1:0] crc_err_cnt;
    logic [CNT_W-1:0] crc_geof_cnt;

    always #2 clk = ~clk;

    fc_crc_inline_marker #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .in_valid(in_valid), .in_word(in_word), .in_tag(in_tag),
        .out_valid(out_valid), .out_word(out_word), .out_tag(out_tag),
        .crc_err_cnt(crc_err_cnt), .crc_geof_cnt(crc_geof_cnt)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference model state.
    bit          m_open = 0;
    logic [31:0] m_q[$];
    logic        e_valid = 0;
    logic [31:0] e_word = '0;
    logic [2:0]  e_tag = '0;
    int          e_err = 0;
    int          e_geof = 0;

    function automatic logic [31:0] crc_words(input logic [31:0] q[$], input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++)
            for (int b = 31; b >= 0; b--) begin
                logic fb = c[31] ^ q[i][b];
                c = c << 1;
                if (fb) c = c ^ POLY;
            end
        return c;
    endfunction

    task automatic compare(input string req);
        compared++;
        if (out_valid !== e_valid) begin
            mismatched++;
            $display("FAIL %s out_valid got %0b exp %0b", req, out_valid, e_valid);
        end else if (e_valid && out_word !== e_word) begin
            mismatched++;
            $display("FAIL %s out_word got %h exp %h", req, out_word, e_word);
        end else if (e_valid && out_tag !== e_tag) begin
            mismatched++;
            $display("FAIL %s out_tag got %0d exp %0d", req, out_tag, e_tag);
        end else if (crc_err_cnt !== CNT_W'(e_err) || crc_geof_cnt !== CNT_W'(e_geof)) begin
            mismatched++;
            $display("FAIL %s counters got %0d/%0d exp %0d/%0d", req,
                     crc_err_cnt, crc_geof_cnt, e_err, e_geof);
        end
    endtask

    task automatic model(input logic v, input logic [31:0] w, input logic [2:0] t, input logic clr);
        bit f_any = 0, f_good = 0;
        e_valid = v;
        if (v) begin
            e_word = w;
            e_tag  = t;
            if (t == 3'd1) begin
                m_q.delete();
                m_q.push_back(w);
                m_open = 1;
            end else if (t == 3'd0) begin
                if (m_open) m_q.push_back(w);
            end else if (t >= 3'd2 && t <= 3'd5 && m_open) begin
                f_any  = (~crc_words(m_q, m_q.size() - 1)) != m_q[m_q.size() - 1];
                f_good = f_any && (t == 3'd2 || t == 3'd3);
                if (f_good) e_tag = t + 3'd2;
                m_open = 0;
            end
        end
        if (clr) begin
            e_err = 0; e_geof = 0;
        end else begin
            if (f_any && e_err < TOPC) e_err++;
            if (f_good && e_geof < TOPC) e_geof++;
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic [2:0] t,
                        input logic clr, input string req);
        @(negedge clk);
        compare(req);
        in_valid = v; in_word = w; in_tag = t; cnt_clr = clr;
        model(v, w, t, clr);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 3'd0, 1'b0, req);
    endtask

    // Frame of start word, n payload words, CRC word, end delimiter.
    task automatic frame(input int n, input bit bad, input logic [2:0] eof,
                         input bit clr_at_eof, input string req);
        logic [31:0] q[$];
        q.push_back($urandom);
        for (int i = 0; i < n; i++) q.push_back($urandom);
        step(1'b1, q[0], 3'd1, 1'b0, req);
        for (int i = 1; i <= n; i++) step(1'b1, q[i], 3'd0, 1'b0, req);
        step(1'b1, ~crc_words(q, n + 1) ^ (bad ? 32'h0000_0100 : 32'h0), 3'd0, 1'b0, req);
        step(1'b1, 32'hE0F0_0000 | 32'(eof), eof, clr_at_eof, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 0, 0, 0, "R11 reset state");
        frame(4, 0, 3'd2, 0, "R10 R2 good normal end");
        frame(2, 0, 3'd3, 0, "R10 R2 good terminate end");
        frame(3, 1, 3'd2, 0, "R3 R5 R6 bad normal end");
        idle(2, "R1 idle gap");
        frame(5, 1, 3'd3, 0, "R3 R5 R6 bad terminate end");
        frame(2, 1, 3'd4, 0, "R4 R5 bad already-invalid normal");
        frame(1, 1, 3'd5, 0, "R4 R5 bad already-invalid terminate");
        frame(2, 0, 3'd5, 0, "R4 good already-invalid");
        frame(0, 0, 3'd2, 0, "R2 zero-payload good");
        frame(0, 1, 3'd3, 0, "R2 zero-payload bad");
        // Primitives between and inside a frame.
        step(1'b1, 32'hBC95_B5B5, 3'd6, 0, "R7 primitive outside frame");
        begin
            logic [31:0] q[$];
            q.push_back(32'h2200_0010); q.push_back(32'h1234_5678); q.push_back(32'h9ABC_DEF0);
            step(1'b1, q[0], 3'd1, 0, "R7 start");
            step(1'b1, q[1], 3'd0, 0, "R7 payload");
            step(1'b1, 32'hBC95_0000, 3'd6, 0, "R7 primitive inside frame");
            step(1'b1, 32'h7777_0000, 3'd7, 0, "R7 reserved inside frame");
            step(1'b1, q[2], 3'd0, 0, "R7 payload");
            step(1'b1, ~crc_words(q, 3), 3'd0, 0, "R7 crc");
            step(1'b1, 32'hE0F0_0002, 3'd2, 0, "R7 end good despite primitives");
        end
        // Abort by a second start delimiter.
        step(1'b1, 32'h1111_1111, 3'd1, 0, "R8 first start");
        step(1'b1, 32'h2222_2222, 3'd0, 0, "R8 payload");
        frame(3, 0, 3'd2, 0, "R8 restarted frame good");
        step(1'b1, 32'h3333_3333, 3'd1, 0, "R8 start then abort");
        frame(1, 1, 3'd2, 0, "R8 restarted frame bad");
        // Stray words outside any frame.
        step(1'b1, 32'hE0F0_0002, 3'd2, 0, "R12 stray end");
        step(1'b1, 32'hDEAD_BEEF, 3'd0, 0, "R12 stray data");
        step(1'b1, 32'hE0F0_0003, 3'd3, 0, "R12 stray end");
        // Saturation, then clear colliding with a failure.
        step(1'b0, 0, 0, 1, "R9 clear");
        for (int i = 0; i < TOPC + 3; i++) frame(1, 1, 3'd2, 0, "R9 saturation");
        frame(1, 1, 3'd3, 1, "R9 clear beats increment");
        frame(2, 1, 3'd2, 0, "R9 counting after clear");
        // Back-to-back frames, no gaps.
        for (int i = 0; i < 6; i++) frame(i, i % 2, 3'(2 + (i % 2)), 0, "R1 R3 back-to-back");
        idle(3, "R1 drain");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired got hang exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule